// File: doc/BRIEF.md
# Enhanced Parallel Cycle Gate

This unit sits between a host register port and a downstream byte channel of a parallel-port controller. It issues enhanced-mode transfers for the host. Offset 3 is the address transfer register and offset 4 is the data transfer register. Each transfer may start only when the stored control byte holds a fixed pattern on the direction bit and the four line-signal bits. Any other pattern blocks the transfer. A blocked write then does nothing, and a blocked read completes at once with ones.

Data accesses at offset 4 can be one, two or four bytes wide. A wide access is split into single-byte downstream requests, lowest byte first. The host port stalls until the whole access is finished. If the downstream side answers with an error, the unit sets a sticky timeout flag and abandons the rest of the access. That flag appears as bit 0 of the status register, and software clears it by writing a 1 to that bit.

The unit also keeps the data latch (offset 0) and the control byte (offset 2). A write that would not change either one sends nothing downstream. A write that flips the direction bit also produces a direction-change request.

Top module: `par_cycle_gate`

## Requirements
- R1: After reset, offset 0 reads 0xFF, offset 2 reads 0xCC, status bit 0 reads 0, and no downstream request is active.
- R2: A write at offset 3 (kind 2) or offset 4 (kind 3) goes downstream only when control AND 0x2F equals 0x04. Otherwise the write completes with no downstream request.
- R3: A read at offset 3 (kind 4) or offset 4 (kind 5) goes downstream only when control AND 0x2F equals 0x24. Otherwise the read returns ones across the access width, and the upper bytes are zero.
- R4: At offset 4, size code 0 moves 1 byte, code 1 moves 2 bytes, and codes 2 and 3 move 4 bytes. Byte i of a wide access travels as the i-th request, and read byte i lands in bits 8i+7:8i.
- R5: An error response on any request of kind 2 to 5 sets a sticky timeout flag. An error on kind 0 or kind 1 does not set it. A status read (offset 1) returns line_status in bits 7:1 and the flag in bit 0.
- R6: A status write with bit 0 set clears the flag. A status write with bit 0 clear leaves the flag unchanged.
- R7: After an error response, the remaining bytes of the access are not requested. In a read result, the failed byte and every later byte read as ones.
- R8: A data-latch write (offset 0) whose byte differs from the stored byte stores it and sends one kind-0 request carrying the byte. An equal byte sends nothing.
- R9: A control write (offset 2) forces bits 7:6 to 1. If the result differs from the stored control, it is stored and sent as one kind-1 request. If it is equal, nothing is sent.
- R10: A control write that flips bit 5 pulses dir_req for exactly one cycle, and dir_read then shows the new bit 5.
- R11: host_ready stays low until the last byte of a downstream access is acknowledged. Each downstream request holds its kind and byte until acknowledged.
- R12: Offsets 5 to 7 read 0xFF, and writes to them send nothing downstream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request, held until host_ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | Width code for offset 4 (0:1, 1:2, 2/3:4 bytes) |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | Access completes in this cycle |
| host_rdata | output | 32 | Read data, valid with host_ready |
| line_status | input | 7 | Status line levels shown in status bits 7:1 |
| dn_valid | output | 1 | Downstream byte request |
| dn_kind | output | 3 | Request kind 0..5 |
| dn_wdata | output | 8 | Byte sent with the request |
| dn_ack | input | 1 | Downstream completes the current request |
| dn_err | input | 1 | Error response, qualified by dn_ack |
| dn_rdata | input | 8 | Read byte, qualified by dn_ack |
| dir_req | output | 1 | One-cycle direction-change request |
| dir_read | output | 1 | Current direction bit (1 = read) |

## Verification
The transfer registers are tried under three control patterns: the power-up value, the write-open value and the read-open value. This shows that the gate compares the masked pattern exactly and does not test single bits. Wide reads and writes use distinct byte values, and downstream acknowledges arrive both at once and after wait states. This exposes wrong byte order and a host_ready that rises early. Errors are injected at the first, middle and later bytes, and also on data-latch requests. These runs separate a missing stop after an error, wrong ones-filling, and a flag set by the wrong request kinds. Repeated equal writes, and control writes that do or do not flip direction, check that the write filtering and the direction request behave as required.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [2:0] {
    DK_DLATCH = 3'd0,
    DK_CTRL   = 3'd1,
    DK_AWR    = 3'd2,
    DK_DWR    = 3'd3,
    DK_ARD    = 3'd4,
    DK_DRD    = 3'd5
  } dn_kind_e;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_STAT  = 3'd1;
  localparam logic [2:0] OFS_CTRL  = 3'd2;
  localparam logic [2:0] OFS_EADDR = 3'd3;
  localparam logic [2:0] OFS_EDATA = 3'd4;

  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam logic [7:0] CTRL_FORCE = 8'hC0;
  localparam logic [7:0] CTRL_RST   = 8'hCC;
  localparam logic [7:0] DATA_RST   = 8'hFF;
  localparam int         DIR_BIT    = 5;
endpackage

// File: rtl/pcg_regs.sv
module pcg_regs
  import pcg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic [BYTE_W-1:0] data_wv,
  input  logic              ctrl_we,
  input  logic [BYTE_W-1:0] ctrl_wv,
  input  logic              tmo_set,
  input  logic              tmo_clr,
  output logic [BYTE_W-1:0] data_q,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              tmo_q,
  output logic              dir_req
);
  logic [BYTE_W-1:0] data_d, ctrl_d;
  logic              tmo_d, dir_d;

  always_comb begin
    data_d = data_q;
    ctrl_d = ctrl_q;
    tmo_d  = tmo_q;
    dir_d  = 1'b0;
    if (data_we) data_d = data_wv;
    if (ctrl_we) begin
      ctrl_d = ctrl_wv;
      dir_d  = ctrl_wv[DIR_BIT] != ctrl_q[DIR_BIT];
    end
    if (tmo_set)      tmo_d = 1'b1;
    else if (tmo_clr) tmo_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= BYTE_W'(DATA_RST);
      ctrl_q  <= BYTE_W'(CTRL_RST);
      tmo_q   <= 1'b0;
      dir_req <= 1'b0;
    end else begin
      if (data_we) data_q <= data_d;
      if (ctrl_we) ctrl_q <= ctrl_d;
      tmo_q   <= tmo_d;
      dir_req <= dir_d;
    end
  end

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q && !tmo_clr |=> tmo_q); // R5
  AST_DIR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dir_req |=> !dir_req); // R10
endmodule

// File: rtl/pcg_seq.sv
module pcg_seq
  import pcg_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  dn_kind_e          kind,
  input  logic [$clog2(HOST_W/BYTE_W+1)-1:0] nbytes,
  input  logic [HOST_W-1:0] wbuf,
  output logic              idle,
  output logic              done,
  output logic [$clog2(HOST_W/BYTE_W+1)-1:0] cnt,
  output logic [HOST_W-1:0] rbuf,
  output logic              dn_valid,
  output dn_kind_e          dn_kind,
  output logic [BYTE_W-1:0] dn_wdata,
  input  logic              dn_ack,
  input  logic              dn_err,
  input  logic [BYTE_W-1:0] dn_rdata
);
  localparam int NB = HOST_W / BYTE_W;
  localparam int CW = $clog2(NB + 1);
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE} st_e;

  st_e               st_q, st_d;
  logic [CW-1:0]     idx_q, idx_d, cnt_q, cnt_d;
  dn_kind_e          kind_q, kind_d;
  logic [HOST_W-1:0] wbuf_q, wbuf_d, rbuf_q, rbuf_d;
  logic [BYTE_W-1:0] wbytes [NB];
  logic              last, ld_en;

  for (genvar g = 0; g < NB; g++) begin : g_wbyte
    assign wbytes[g] = wbuf_q[g*BYTE_W +: BYTE_W];
  end

  assign last = (idx_q + CW'(1)) == cnt_q;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    wbuf_d = wbuf_q;
    rbuf_d = rbuf_q;
    ld_en  = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        st_d   = S_XFER;
        idx_d  = '0;
        cnt_d  = nbytes;
        kind_d = kind;
        wbuf_d = wbuf;
        rbuf_d = '1;
        ld_en  = 1'b1;
      end
      S_XFER: if (dn_ack) begin
        if (dn_err) begin
          st_d = S_DONE;
        end else begin
          for (int i = 0; i < NB; i++)
            if (idx_q == CW'(i)) rbuf_d[i*BYTE_W +: BYTE_W] = dn_rdata;
          idx_d = idx_q + CW'(1);
          if (last) st_d = S_DONE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      kind_q <= DK_DLATCH;
      wbuf_q <= '0;
      rbuf_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      rbuf_q <= rbuf_d;
      if (ld_en) begin
        cnt_q  <= cnt_d;
        kind_q <= kind_d;
        wbuf_q <= wbuf_d;
      end
    end
  end

  assign idle     = st_q == S_IDLE;
  assign done     = st_q == S_DONE;
  assign cnt      = cnt_q;
  assign rbuf     = rbuf_q;
  assign dn_valid = st_q == S_XFER;
  assign dn_kind  = kind_q;
  assign dn_wdata = wbytes[idx_q[IW-1:0]];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ack |=> dn_valid && $stable(dn_wdata) && $stable(dn_kind)); // R11
  AST_STOP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ack && dn_err |=> !dn_valid && done); // R7
endmodule

// File: rtl/par_cycle_gate.sv
module par_cycle_gate
  import pcg_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [2:0]        host_addr,
  input  logic [1:0]        host_size,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [HOST_W-1:0] host_rdata,
  input  logic [BYTE_W-1:1] line_status,
  output logic              dn_valid,
  output logic [2:0]        dn_kind,
  output logic [BYTE_W-1:0] dn_wdata,
  input  logic              dn_ack,
  input  logic              dn_err,
  input  logic [BYTE_W-1:0] dn_rdata,
  output logic              dir_req,
  output logic              dir_read
);
  localparam int NB = HOST_W / BYTE_W;
  localparam int CW = $clog2(NB + 1);

  logic [BYTE_W-1:0] data_q, ctrl_q, ctrl_new;
  logic              tmo_q, tmo_set, tmo_clr, data_we, ctrl_we;
  logic              seq_idle, seq_done, need, accept, start, wr_open, rd_open;
  logic [CW-1:0]     acc_nb, seq_cnt, mask_nb;
  logic [HOST_W-1:0] raw, rmask, seq_rbuf, wbuf;
  dn_kind_e          kind, seq_kind;

  assign ctrl_new = host_wdata[BYTE_W-1:0] | BYTE_W'(CTRL_FORCE);
  assign wr_open  = (ctrl_q & BYTE_W'(GATE_MASK)) == BYTE_W'(GATE_WR);
  assign rd_open  = (ctrl_q & BYTE_W'(GATE_MASK)) == BYTE_W'(GATE_RD);

  always_comb begin
    acc_nb = CW'(1);
    if (host_addr == OFS_EDATA) begin
      case (host_size)
        2'd0:    acc_nb = CW'(1);
        2'd1:    acc_nb = CW'(2);
        default: acc_nb = CW'(NB);
      endcase
    end
  end

  always_comb begin
    need = 1'b0;
    kind = DK_DLATCH;
    raw  = '1;
    if (host_write) begin
      case (host_addr)
        OFS_DATA:  begin need = host_wdata[BYTE_W-1:0] != data_q; kind = DK_DLATCH; end
        OFS_CTRL:  begin need = ctrl_new != ctrl_q;               kind = DK_CTRL;   end
        OFS_EADDR: begin need = wr_open;                          kind = DK_AWR;    end
        OFS_EDATA: begin need = wr_open;                          kind = DK_DWR;    end
        default:   need = 1'b0;
      endcase
    end else begin
      case (host_addr)
        OFS_DATA:  raw = HOST_W'(data_q);
        OFS_STAT:  raw = HOST_W'({line_status, tmo_q});
        OFS_CTRL:  raw = HOST_W'(ctrl_q);
        OFS_EADDR: begin need = rd_open; kind = DK_ARD; end
        OFS_EDATA: begin need = rd_open; kind = DK_DRD; end
        default:   raw = '1;
      endcase
    end
    if (seq_done) raw = seq_rbuf;
  end

  assign accept  = seq_idle && host_valid;
  assign start   = accept && need;
  assign data_we = start && host_write && (host_addr == OFS_DATA);
  assign ctrl_we = start && host_write && (host_addr == OFS_CTRL);
  assign tmo_clr = accept && host_write && (host_addr == OFS_STAT) && host_wdata[0];
  assign tmo_set = dn_valid && dn_ack && dn_err && (seq_kind >= DK_AWR);
  assign wbuf    = (host_addr == OFS_CTRL) ? HOST_W'(ctrl_new) : host_wdata;

  assign host_ready = (accept && !need) || seq_done;
  assign mask_nb    = seq_done ? seq_cnt : acc_nb;

  for (genvar g = 0; g < NB; g++) begin : g_rmask
    assign rmask[g*BYTE_W +: BYTE_W] = (CW'(g) < mask_nb) ? '1 : '0;
  end
  assign host_rdata = raw & rmask;

  pcg_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .data_we(data_we), .data_wv(host_wdata[BYTE_W-1:0]),
    .ctrl_we(ctrl_we), .ctrl_wv(ctrl_new),
    .tmo_set(tmo_set), .tmo_clr(tmo_clr),
    .data_q(data_q), .ctrl_q(ctrl_q), .tmo_q(tmo_q), .dir_req(dir_req)
  );

  pcg_seq #(.HOST_W(HOST_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .kind(kind), .nbytes(acc_nb), .wbuf(wbuf),
    .idle(seq_idle), .done(seq_done), .cnt(seq_cnt), .rbuf(seq_rbuf),
    .dn_valid(dn_valid), .dn_kind(seq_kind), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_err(dn_err), .dn_rdata(dn_rdata)
  );

  assign dn_kind  = seq_kind;
  assign dir_read = ctrl_q[DIR_BIT];

  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && (dn_kind == DK_AWR || dn_kind == DK_DWR)
      |-> (ctrl_q & BYTE_W'(GATE_MASK)) == BYTE_W'(GATE_WR)); // R2
  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && (dn_kind == DK_ARD || dn_kind == DK_DRD)
      |-> (ctrl_q & BYTE_W'(GATE_MASK)) == BYTE_W'(GATE_RD)); // R3
  AST_TMO_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ack && dn_err && dn_kind >= DK_AWR |=> tmo_q); // R5
  AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !host_ready); // R11
endmodule

// File: tb/test_par_cycle_gate.sv
module test_par_cycle_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic [7:1]  line_status = 7'b0101101;
  logic        dn_valid;
  logic [2:0]  dn_kind;
  logic [7:0]  dn_wdata;
  logic        dn_ack = 1'b0, dn_err = 1'b0;
  logic [7:0]  dn_rdata = '0;
  logic        dir_req, dir_read;

  par_cycle_gate i_par_cycle_gate (.*);

  always #4 clk = ~clk;  // 125 MHz

  int vectors = 0, fails = 0, cycles = 0;
  int ack_delay = 0, err_at = -1, resp_idx = 0, wcnt = 0, dir_cnt = 0;
  bit in_acc = 1'b1;
  logic [10:0] log_q[$];
  logic [7:0]  m_data = 8'hFF, m_ctrl = 8'hCC;
  bit          m_tmo = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // downstream responder, driven away from the active edge
  always @(negedge clk) begin
    if (dn_ack) begin
      dn_ack = 1'b0; dn_err = 1'b0; wcnt = 0;
    end else if (dn_valid) begin
      if (wcnt >= ack_delay) begin
        dn_ack   = 1'b1;
        dn_err   = (resp_idx == err_at);
        dn_rdata = 8'hA0 + 8'(resp_idx);
        log_q.push_back({dn_kind, dn_wdata});
        resp_idx++;
      end else wcnt++;
    end
  end

  // per-clock monitor
  always @(negedge clk) begin
    #2;
    if (dir_req) dir_cnt++;
    if (rst_n && !in_acc)
      chk(!dn_valid && !host_ready, "R11", "idle outputs quiet",
          {30'b0, dn_valid, host_ready}, 32'h0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic acc(input bit wr, input int ofs, input int sz, input logic [31:0] wd,
                     input string req);
    logic [10:0] exp_q[$];
    logic [31:0] exp_rd, got;
    logic [7:0]  v;
    int nb, k, d0;
    bit exp_dir;
    nb = (ofs == 4) ? ((sz == 0) ? 1 : (sz == 1) ? 2 : 4) : 1;
    exp_rd = 32'h0; exp_dir = 1'b0;
    if (wr) begin
      case (ofs)
        0: if (wd[7:0] != m_data) begin exp_q.push_back({3'd0, wd[7:0]}); m_data = wd[7:0]; end
        1: if (wd[0]) m_tmo = 1'b0;
        2: begin
          v = wd[7:0] | 8'hC0;
          if (v != m_ctrl) begin
            exp_dir = v[5] != m_ctrl[5];
            exp_q.push_back({3'd1, v}); m_ctrl = v;
          end
        end
        3, 4: if ((m_ctrl & 8'h2F) == 8'h04) begin
          k = (ofs == 3) ? 2 : 3;
          for (int i = 0; i < nb; i++) begin
            exp_q.push_back({3'(k), wd[8*i +: 8]});
            if (i == err_at) begin m_tmo = 1'b1; break; end
          end
        end
        default: ;
      endcase
    end else begin
      case (ofs)
        0: exp_rd = {24'h0, m_data};
        1: exp_rd = {24'h0, line_status, m_tmo};
        2: exp_rd = {24'h0, m_ctrl};
        3, 4: begin
          for (int i = 0; i < nb; i++) exp_rd[8*i +: 8] = 8'hFF;
          if ((m_ctrl & 8'h2F) == 8'h24) begin
            k = (ofs == 3) ? 4 : 5;
            for (int i = 0; i < nb; i++) begin
              exp_q.push_back({3'(k), wd[8*i +: 8]});
              if (i == err_at) begin m_tmo = 1'b1; break; end
              exp_rd[8*i +: 8] = 8'hA0 + 8'(i);
            end
          end
        end
        default: exp_rd = 32'hFF;
      endcase
    end
    in_acc = 1'b1;
    @(negedge clk);
    log_q.delete(); resp_idx = 0; d0 = dir_cnt;
    host_valid = 1'b1; host_write = wr; host_addr = 3'(ofs);
    host_size = 2'(sz); host_wdata = wd;
    #1;
    while (!host_ready) begin @(negedge clk); #1; end
    got = host_rdata;
    chk(log_q.size() == exp_q.size(), req, "downstream request count",
        32'(log_q.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
      chk(log_q[i] == exp_q[i], req, "downstream {kind,byte}",
          {21'b0, log_q[i]}, {21'b0, exp_q[i]});
    if (!wr) chk(got == exp_rd, req, "read data", got, exp_rd);
    @(negedge clk);
    host_valid = 1'b0;
    @(negedge clk); #3;
    chk((dir_cnt - d0) == (exp_dir ? 1 : 0), "R10", "dir_req pulses",
        32'(dir_cnt - d0), exp_dir ? 32'd1 : 32'd0);
    chk(dir_read == m_ctrl[5], "R10", "dir_read", {31'b0, dir_read}, {31'b0, m_ctrl[5]});
    in_acc = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk(!dn_valid && !dir_req, "R1", "reset outputs", {30'b0, dn_valid, dir_req}, 32'h0);
    in_acc = 1'b0;
    acc(0, 0, 0, 0, "R1");
    acc(0, 2, 0, 0, "R1");
    acc(0, 1, 0, 0, "R1");
    // gated off under reset control pattern
    acc(1, 4, 2, 32'h12345678, "R2");
    acc(1, 3, 0, 32'h55, "R2");
    acc(0, 4, 2, 0, "R3");
    acc(0, 4, 1, 0, "R3");
    acc(0, 3, 0, 0, "R3");
    // open for writes
    acc(1, 2, 0, 32'h04, "R9");
    acc(1, 2, 0, 32'h04, "R9");
    acc(1, 3, 0, 32'h37, "R2");
    acc(1, 4, 2, 32'h11223344, "R4");
    acc(1, 4, 1, 32'h0000BEEF, "R4");
    acc(1, 4, 0, 32'h0000007E, "R4");
    acc(1, 4, 3, 32'hCAFEF00D, "R4");
    acc(0, 4, 2, 0, "R3");
    ack_delay = 3;
    acc(1, 4, 2, 32'h89ABCDEF, "R11");
    ack_delay = 0;
    // open for reads
    acc(1, 2, 0, 32'h24, "R10");
    acc(0, 4, 2, 0, "R4");
    acc(0, 4, 1, 0, "R4");
    acc(0, 3, 0, 0, "R3");
    acc(1, 4, 2, 32'h01020304, "R2");
    acc(1, 2, 0, 32'hE4, "R9");
    // errors
    err_at = 1;
    acc(0, 4, 2, 0, "R7");
    err_at = -1;
    acc(0, 1, 0, 0, "R5");
    acc(1, 1, 0, 32'hFE, "R6");
    acc(0, 1, 0, 0, "R6");
    acc(1, 1, 0, 32'h01, "R6");
    acc(0, 1, 0, 0, "R6");
    err_at = 0;
    acc(0, 3, 0, 0, "R5");
    err_at = -1;
    acc(0, 1, 0, 0, "R5");
    acc(1, 1, 0, 32'h01, "R6");
    acc(1, 2, 0, 32'h04, "R10");
    ack_delay = 2; err_at = 2;
    acc(1, 4, 2, 32'hA1B2C3D4, "R7");
    ack_delay = 0; err_at = -1;
    acc(0, 1, 0, 0, "R5");
    acc(1, 1, 0, 32'h01, "R6");
    // data latch and error on non-transfer kinds
    acc(1, 0, 0, 32'h5A, "R8");
    acc(1, 0, 0, 32'h5A, "R8");
    acc(0, 0, 0, 0, "R8");
    err_at = 0;
    acc(1, 0, 0, 32'h33, "R5");
    acc(1, 2, 0, 32'h0C, "R5");
    err_at = -1;
    acc(0, 1, 0, 0, "R5");
    acc(0, 2, 0, 0, "R9");
    // unused offsets
    acc(1, 6, 0, 32'h77, "R12");
    acc(1, 5, 0, 32'h11, "R12");
    acc(0, 7, 0, 0, "R12");
    acc(0, 5, 2, 0, "R12");
    acc(0, 0, 0, 0, "R12");
    repeat (4) @(negedge clk);
    summary();
  end
endmodule